// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block takes in 8-bit words from a synchronous serial link in which a shift clock travels beside a single data line. Both lines are brought into the system clock domain through a synchronizer. Each rising edge of the shift clock moves one bit into a shift register, least significant bit first. After the eighth bit, the word goes to a holding register that the CPU reads. This happens only if the CPU has consumed the previous word, which it signals by clearing the data-full flag.

If a word completes while the holding register is still full, the block does not overwrite the register. It raises an overrun error instead. The overrun stops all further reception until software clears the error with a one-cycle strobe. That clear also restarts bit counting on a fresh frame boundary.

A single interrupt enable gates two level-type requests: one for data-full and one for error. A receive-enable input held low keeps the bit counter and the shift register at zero and ignores the serial clock.

Top module: `srx_sync_receiver`

## Requirements
- R1: Bits are taken LSB first: the first bit received in a frame lands in `rx_word[0]` and the eighth in `rx_word[7]`.
- R2: When a frame completes while `rx_full` is 0, `rx_word` takes the new word and `rx_full` becomes 1.
- R3: When a frame completes while `rx_full` is 1 and no clear is pending, `rx_ovr` becomes 1, `rx_word` keeps its old value and `rx_full` stays 1.
- R4: A one-cycle `full_clr` strobe drops `rx_full` to 0. If that strobe falls in the same cycle as a frame completion, the frame is accepted as in R2 and no overrun is raised.
- R5: `irq_rx` is high exactly while `rx_full` and `irq_en` are both 1.
- R6: `irq_err` is high exactly while `rx_ovr` and `irq_en` are both 1.
- R7: While `rx_ovr` is 1, no frame is received: `rx_full` cannot rise and `rx_word` does not change.
- R8: A one-cycle `err_clr` strobe drops `rx_ovr` to 0. The next eight serial clock rising edges then form a complete new frame.
- R9: While `rx_en` is 0, the serial clock is ignored and the bit counter is held at zero. A frame that was partly received when `rx_en` fell is discarded.
- R10: After reset, `rx_word` is 0x00 and `rx_full`, `rx_ovr`, `irq_rx` and `irq_err` are all 0.
- R11: Data is sampled on the rising edge of `ser_clk`, seen through a two-stage synchronizer. `clk` must run at least four times as fast as `ser_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; 0 holds the receiver idle |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_data | input | 1 | Serial data line |
| irq_en | input | 1 | Shared enable for both interrupt requests |
| full_clr | input | 1 | One-cycle strobe that clears the data-full flag |
| err_clr | input | 1 | One-cycle strobe that clears the overrun flag |
| rx_word | output | 8 | Receive data register |
| rx_full | output | 1 | Data-full flag |
| rx_ovr | output | 1 | Overrun error flag |
| irq_rx | output | 1 | Data-full interrupt request (level) |
| irq_err | output | 1 | Error interrupt request (level) |

## Verification
The data-full clear and the completion of a frame can land in the same system clock cycle. That is the point where the design must decide between accepting the word and raising an overrun. The bench provokes this case by counting the synchronizer delay and pulsing `full_clr` exactly on the cycle in which the eighth bit is shifted in. It then expects the new word in `rx_word`, with `rx_full` at 1 and `rx_ovr` at 0. A design that gives completion priority over the clear would show an overrun and keep the old word.

// File: rtl/srx_pkg.sv
package srx_pkg;
   localparam int unsigned SRX_MIN_SYNC = 2;

   typedef enum logic [1:0] {
      FR_NONE     = 2'd0,
      FR_LOAD     = 2'd1,
      FR_OVERRUN  = 2'd2
   } srx_event_e;
endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_clk,
   input  logic ser_data,
   output logic clk_rise,
   output logic data_s
);
   logic [STAGES-1:0] clk_pipe;
   logic [STAGES-1:0] dat_pipe;
   logic              clk_last;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  clk_pipe[g] <= 1'b0;
                  dat_pipe[g] <= 1'b0;
               end else begin
                  clk_pipe[g] <= ser_clk;
                  dat_pipe[g] <= ser_data;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  clk_pipe[g] <= 1'b0;
                  dat_pipe[g] <= 1'b0;
               end else begin
                  clk_pipe[g] <= clk_pipe[g-1];
                  dat_pipe[g] <= dat_pipe[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) clk_last <= 1'b0;
      else        clk_last <= clk_pipe[STAGES-1];
   end

   assign clk_rise = clk_pipe[STAGES-1] & ~clk_last;
   assign data_s   = dat_pipe[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              shift,
   input  logic              bit_in,
   output logic [DATA_W-1:0] word_next,
   output logic              done
);
   localparam int unsigned CNT_W = $clog2(DATA_W);
   localparam int unsigned LAST  = DATA_W - 1;

   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;

   assign word_next = {bit_in, shreg[DATA_W-1:1]};
   assign done      = run & shift & (cnt == CNT_W'(LAST));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (shift) begin
         shreg <= word_next;
         cnt   <= done ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/srx_flags.sv
module srx_flags
   import srx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] word_in,
   input  logic              full_clr,
   input  logic              err_clr,
   output logic [DATA_W-1:0] word_q,
   output logic              full_q,
   output logic              ovr_q
);
   srx_event_e ev;

   always_comb begin
      ev = FR_NONE;
      if (done) ev = (full_q && !full_clr) ? FR_OVERRUN : FR_LOAD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (ev == FR_LOAD) begin
            word_q <= word_in;
            full_q <= 1'b1;
         end else if (full_clr) begin
            full_q <= 1'b0;
         end
         if (ev == FR_OVERRUN) ovr_q <= 1'b1;
         else if (err_clr)     ovr_q <= 1'b0;
      end
   end
endmodule

// File: rtl/srx_sync_receiver.sv
module srx_sync_receiver
   import srx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              irq_en,
   input  logic              full_clr,
   input  logic              err_clr,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_full,
   output logic              rx_ovr,
   output logic              irq_rx,
   output logic              irq_err
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("srx_sync_receiver: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < SRX_MIN_SYNC) begin : g_bad_sync
         $error("srx_sync_receiver: SYNC_STAGES below minimum");
      end
   endgenerate

   logic              sclk_rise;
   logic              sdata;
   logic              run;
   logic              frame_done;
   logic [DATA_W-1:0] frame_word;

   assign run = rx_en & ~rx_ovr;

   srx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_clk  (ser_clk),
      .ser_data (ser_data),
      .clk_rise (sclk_rise),
      .data_s   (sdata)
   );

   srx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .shift     (sclk_rise),
      .bit_in    (sdata),
      .word_next (frame_word),
      .done      (frame_done)
   );

   srx_flags #(.DATA_W(DATA_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (frame_done),
      .word_in  (frame_word),
      .full_clr (full_clr),
      .err_clr  (err_clr),
      .word_q   (rx_word),
      .full_q   (rx_full),
      .ovr_q    (rx_ovr)
   );

   assign irq_rx  = rx_full & irq_en;
   assign irq_err = rx_ovr & irq_en;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en,
   input logic              irq_en,
   input logic              full_clr,
   input logic              err_clr,
   input logic [DATA_W-1:0] rx_word,
   input logic              rx_full,
   input logic              rx_ovr,
   input logic              irq_rx,
   input logic              irq_err
);
   assert_ovr_keeps_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr) |-> ($stable(rx_word) && rx_full));

   assert_lock_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr |=> (!$rose(rx_full) && $stable(rx_word)));

   assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovr && !err_clr) |=> rx_ovr);

   assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!$rose(rx_full) && !$rose(rx_ovr)));

   assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq_rx);

   assert_err_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && rx_ovr) |-> irq_err);

   assert_clear_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full_clr && rx_full) |=> (!rx_full || !rx_ovr));
endmodule

bind srx_sync_receiver srx_checker #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_en    (rx_en),
   .irq_en   (irq_en),
   .full_clr (full_clr),
   .err_clr  (err_clr),
   .rx_word  (rx_word),
   .rx_full  (rx_full),
   .rx_ovr   (rx_ovr),
   .irq_rx   (irq_rx),
   .irq_err  (irq_err)
);

// File: tb/sim_srx_sync_receiver.sv
module sim_srx_sync_receiver;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_data = 1'b0;
   logic       irq_en = 1'b0;
   logic       full_clr = 1'b0;
   logic       err_clr = 1'b0;
   logic [7:0] rx_word;
   logic       rx_full, rx_ovr, irq_rx, irq_err;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   srx_sync_receiver u0 (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ser_clk(ser_clk),
      .ser_data(ser_data), .irq_en(irq_en), .full_clr(full_clr),
      .err_clr(err_clr), .rx_word(rx_word), .rx_full(rx_full),
      .rx_ovr(rx_ovr), .irq_rx(irq_rx), .irq_err(irq_err)
   );

   // vector: {clear_first, data, exp_full, exp_ovr, exp_word}
   localparam int NVEC = 5;
   localparam logic [18:0] VEC [NVEC] = '{
      {1'b0, 8'hA5, 1'b1, 1'b0, 8'hA5},
      {1'b1, 8'h3C, 1'b1, 1'b0, 8'h3C},
      {1'b1, 8'h01, 1'b1, 1'b0, 8'h01},
      {1'b1, 8'h80, 1'b1, 1'b0, 8'h80},
      {1'b0, 8'hFF, 1'b1, 1'b1, 8'h80}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic send_bits(input logic [7:0] w, input int nbits, input bit strobe_last);
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         ser_clk  = 1'b0;
         ser_data = w[i];
         repeat (3) @(negedge clk);
         ser_clk = 1'b1;
         if (strobe_last && i == nbits - 1) begin
            repeat (2) @(negedge clk);
            full_clr = 1'b1;
            @(negedge clk);
            full_clr = 1'b0;
            @(negedge clk);
         end else begin
            repeat (4) @(negedge clk);
         end
      end
      @(negedge clk);
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_full_clr();
      @(negedge clk); full_clr = 1'b1;
      @(negedge clk); full_clr = 1'b0;
   endtask

   task automatic pulse_err_clr();
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10 reset state
      check("R10 word", rx_word, 8'h00);
      check("R10 flags", {rx_full, rx_ovr, irq_rx, irq_err}, 4'b0000);
      rst_n = 1'b1;
      rx_en = 1'b1;
      irq_en = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2 R3 R11: table walk, LSB-first words, last one overruns
      for (int v = 0; v < NVEC; v++) begin
         if (VEC[v][18]) pulse_full_clr();
         send_bits(VEC[v][17:10], 8, 1'b0);
         check("R1_R2 word", rx_word, VEC[v][7:0]);
         check("R2_R3 full", rx_full, VEC[v][9]);
         check("R3 ovr", rx_ovr, VEC[v][8]);
         check("R5 irq_rx", irq_rx, VEC[v][9]);
         check("R6 irq_err", irq_err, VEC[v][8]);
      end

      // R7: locked after overrun
      pulse_full_clr();
      check("R4 clear", rx_full, 1'b0);
      send_bits(8'h55, 8, 1'b0);
      check("R7 no load full", rx_full, 1'b0);
      check("R7 word held", rx_word, 8'h80);
      irq_en = 1'b0;
      @(negedge clk);
      check("R6 gated", irq_err, 1'b0);
      irq_en = 1'b1;

      // R8: clear error, fresh frame
      pulse_err_clr();
      check("R8 ovr cleared", rx_ovr, 1'b0);
      check("R6 err drop", irq_err, 1'b0);
      send_bits(8'h55, 8, 1'b0);
      check("R8 restart word", rx_word, 8'h55);
      check("R8 restart full", rx_full, 1'b1);

      // R5: enable gating
      irq_en = 1'b0;
      @(negedge clk);
      check("R5 gated", irq_rx, 1'b0);
      irq_en = 1'b1;
      @(negedge clk);
      check("R5 enabled", irq_rx, 1'b1);

      // R4: clear coincides with frame completion
      send_bits(8'hC3, 8, 1'b1);
      check("R4 same-cycle word", rx_word, 8'hC3);
      check("R4 same-cycle full", rx_full, 1'b1);
      check("R4 same-cycle ovr", rx_ovr, 1'b0);

      // R9: disabled receiver ignores clock
      pulse_full_clr();
      rx_en = 1'b0;
      send_bits(8'h0F, 8, 1'b0);
      check("R9 ignored full", rx_full, 1'b0);
      check("R9 ignored word", rx_word, 8'hC3);
      rx_en = 1'b1;
      send_bits(8'hFF, 3, 1'b0);
      @(negedge clk); rx_en = 1'b0;
      @(negedge clk); rx_en = 1'b1;
      send_bits(8'h96, 8, 1'b0);
      check("R9 partial discarded", rx_word, 8'h96);
      check("R9 full after", rx_full, 1'b1);
      check("R9 no ovr", rx_ovr, 1'b0);

      summary();
   end
endmodule